// File: doc/BRIEF.md
# Multi-Lane Serial Flash Protocol Front End

This block is the slave-side serial front end of a flash-style memory. It samples a serial clock, chip select and four bidirectional data lanes with its own system clock. It decodes an 8-bit instruction, gathers a 24-bit address, and then returns data bytes from a byte-wide storage port. On a configuration write, it accepts a data byte instead.

Three lane protocols exist, and only one is in force at a time:

- **Extended single-lane.** The instruction and the address always use one lane. The read instruction then chooses one, two or four lanes for the data.
- **Dual-lane.** Every phase uses two lanes.
- **Quad-lane.** Every phase uses four lanes.

The protocol comes from a two-bit power-up selection taken from a non-volatile image, which is loaded on reset. A volatile selection written at run time overrides it from the next transaction on. A reset throws the override away.

Top module: `sfe_top`

## Requirements
- R1: While `rst_n` is low, the volatile selection reloads from `nv_sel_n` and any earlier override is lost. After reset, `dq_oe` is 0.
- R2: Power-up selection is decoded as follows. If `nv_sel_n[1]` (image bit 3) is 0, the mode is quad-lane, whatever the value of the other bit. Otherwise, if `nv_sel_n[0]` (image bit 2) is 0, the mode is dual-lane. If both bits are 1, the mode is extended single-lane.
- R3: In extended mode, instruction 0x03 works as follows:
  - The instruction and the 24-bit address arrive on DQ0, MSB first.
  - Data bytes leave on DQ1, MSB first.
  - The address advances by one per byte and wraps modulo 2^24.
- R4: In extended mode, instruction 0x3B returns two bits per clock. Bit 7 is on DQ1 and bit 6 is on DQ0 in the first clock.
- R5: In extended mode, instruction 0x6B returns four bits per clock, with bit 7 on DQ3 in the first nibble.
- R6: In dual-lane mode, the instruction, address and data all use DQ1:DQ0, with DQ1 carrying the more significant bit. Each of the opcodes 0x03, 0x3B and 0x6B returns data on two lanes.
- R7: In quad-lane mode, the instruction, address and data all use DQ3:DQ0, with DQ3 carrying the most significant bit. Each of the three read opcodes returns data on four lanes.
- R8: Instruction 0x61 followed by one full data byte writes the volatile selection:
  - If bit 7 is 0, the mode is quad-lane.
  - Otherwise, if bit 6 is 0, the mode is dual-lane.
  - Otherwise, the mode is extended.

  The new mode takes effect only when chip select is released, and only if all 8 data bits arrived.
- R9: Chip select going high does three things: it aborts any partial transaction, it returns the shifter to the instruction phase, and it releases every output lane. A chip-select release wins over a falling clock edge that arrives at the same time.
- R10: Output enables are set only in the data phase of a read, from its first falling clock edge on. The enable mask is 0010 for one lane, 0011 for two lanes and 1111 for four lanes. An unknown opcode leaves every lane released until chip select goes high.
- R11: `dq_out` changes only after a falling serial clock edge, and it holds its value across the rising edge that samples it.
- R12: Clock mode 0 (clock idles low) and clock mode 3 (clock idles high) give identical transfers, with input sampled on rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset (power-up) |
| nv_sel_n | input | 2 | Non-volatile lane selection: [1] quad (active low), [0] dual (active low) |
| sck | input | 1 | Serial clock |
| cs_n | input | 1 | Chip select, active low |
| dq_in | input | 4 | Data lanes as seen on the pins |
| dq_out | output | 4 | Data driven onto the lanes |
| dq_oe | output | 4 | Per-lane output enable |
| mem_addr | output | 24 | Byte address into the storage port |
| mem_rdata | input | 8 | Byte read from storage at `mem_addr` |

## Verification
Two events can fall in the same system-clock cycle: the release of chip select, and a falling serial clock edge during the read data phase. Whenever the bench closes a mode-0 transaction, it drops the serial clock and raises chip select at the same instant. Both changes therefore pass through the synchronizer together. The bench then expects every lane to be released, and it expects the next transaction to decode cleanly from its first instruction bit. The same release also applies a pending volatile selection. That is judged by the lane width of the following read.

// File: rtl/sfe_pkg.sv
package sfe_pkg;

    typedef enum logic [1:0] {
        MODE_EXT  = 2'd0,
        MODE_DUAL = 2'd1,
        MODE_QUAD = 2'd2
    } lane_mode_e;

    typedef enum logic [2:0] {
        PH_CMD  = 3'd0,
        PH_ADDR = 3'd1,
        PH_RD   = 3'd2,
        PH_WR   = 3'd3,
        PH_SKIP = 3'd4
    } phase_e;

    function automatic logic [2:0] mode_lanes(lane_mode_e m);
        case (m)
            MODE_DUAL: return 3'd2;
            MODE_QUAD: return 3'd4;
            default:   return 3'd1;
        endcase
    endfunction

    // active-low selects; quad outranks dual
    function automatic lane_mode_e pick_mode(logic quad_n, logic dual_n);
        if (!quad_n) return MODE_QUAD;
        if (!dual_n) return MODE_DUAL;
        return MODE_EXT;
    endfunction

    function automatic logic [3:0] lane_mask(logic [2:0] w);
        case (w)
            3'd1:    return 4'b0010;
            3'd2:    return 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic [3:0] units_per_byte(logic [2:0] w);
        case (w)
            3'd1:    return 4'd8;
            3'd2:    return 4'd4;
            default: return 4'd2;
        endcase
    endfunction

endpackage

// File: rtl/sfe_sync.sv
module sfe_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic [W-1:0] src;
        logic [W-1:0] q;
        if (s == 0) begin : g_first
            assign src = din;
        end else begin : g_next
            assign src = g_stage[s-1].q;
        end
        always_ff @(posedge clk) begin
            if (!rst_n) q <= RST_VAL;
            else        q <= src;
        end
    end

    assign dout = g_stage[STAGES-1].q;

endmodule

// File: rtl/sfe_cfg.sv
module sfe_cfg
    import sfe_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] nv_sel_n,
    input  logic       we,
    input  logic [1:0] wsel_n,
    output lane_mode_e mode
);

    typedef struct packed {
        logic [1:0] sel_n;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) cfg_d.sel_n = wsel_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q.sel_n <= nv_sel_n;
        else        cfg_q       <= cfg_d;
    end

    assign mode = pick_mode(cfg_q.sel_n[1], cfg_q.sel_n[0]);

endmodule

// File: rtl/sfe_engine.sv
module sfe_engine
    import sfe_pkg::*;
#(
    parameter int         ADDR_W     = 24,
    parameter int         V_QUAD_BIT = 7,
    parameter int         V_DUAL_BIT = 6,
    parameter logic [7:0] OP_RD1     = 8'h03,
    parameter logic [7:0] OP_RD2     = 8'h3B,
    parameter logic [7:0] OP_RD4     = 8'h6B,
    parameter logic [7:0] OP_WCFG    = 8'h61
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_s,
    input  logic              cs_n_s,
    input  logic [3:0]        dq_s,
    input  lane_mode_e        mode,
    input  logic [7:0]        mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [3:0]        dq_out,
    output logic [3:0]        dq_oe,
    output logic              cfg_we,
    output logic [1:0]        cfg_wsel_n
);

    localparam int CNT_W = $clog2(ADDR_W + 1);

    typedef struct packed {
        phase_e            ph;
        logic [ADDR_W-1:0] sr;
        logic [CNT_W-1:0]  cnt;
        logic [2:0]        dw;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        obyte;
        logic [3:0]        orem;
        logic              drive;
        logic [3:0]        dout;
        logic              sck_prev;
        logic              cfg_pend;
        logic [1:0]        cfg_val;
    } eng_t;

    eng_t st_d, st_q;

    logic              rise, fall;
    logic [2:0]        lw, sw;
    logic [ADDR_W-1:0] sr_nx;
    logic [CNT_W-1:0]  cnt_nx;
    logic [7:0]        byte_v, op;

    function automatic logic [ADDR_W-1:0] shift_in(logic [ADDR_W-1:0] sr,
                                                   logic [3:0] dq, logic [2:0] w);
        case (w)
            3'd1:    return {sr[ADDR_W-2:0], dq[0]};
            3'd2:    return {sr[ADDR_W-3:0], dq[1:0]};
            default: return {sr[ADDR_W-5:0], dq[3:0]};
        endcase
    endfunction

    always_comb begin
        st_d          = st_q;
        st_d.sck_prev = sck_s;
        rise   = sck_s & ~st_q.sck_prev;
        fall   = ~sck_s & st_q.sck_prev;
        lw     = mode_lanes(mode);
        sw     = (st_q.ph == PH_WR) ? st_q.dw : lw;
        sr_nx  = shift_in(st_q.sr, dq_s, sw);
        cnt_nx = st_q.cnt + CNT_W'(sw);
        op     = sr_nx[7:0];
        byte_v = (st_q.orem == '0) ? mem_rdata : st_q.obyte;

        if (cs_n_s) begin
            st_d.ph       = PH_CMD;
            st_d.cnt      = '0;
            st_d.drive    = 1'b0;
            st_d.orem     = '0;
            st_d.cfg_pend = 1'b0;
        end else if (rise) begin
            case (st_q.ph)
                PH_CMD: begin
                    st_d.sr  = sr_nx;
                    st_d.cnt = cnt_nx;
                    if (cnt_nx == CNT_W'(8)) begin
                        st_d.cnt = '0;
                        if (op == OP_RD1 || op == OP_RD2 || op == OP_RD4) begin
                            st_d.ph = PH_ADDR;
                            if (mode == MODE_EXT)
                                st_d.dw = (op == OP_RD2) ? 3'd2 : (op == OP_RD4) ? 3'd4 : 3'd1;
                            else
                                st_d.dw = lw;
                        end else if (op == OP_WCFG) begin
                            st_d.ph = PH_WR;
                            st_d.dw = lw;
                        end else begin
                            st_d.ph = PH_SKIP;
                        end
                    end
                end
                PH_ADDR: begin
                    st_d.sr  = sr_nx;
                    st_d.cnt = cnt_nx;
                    if (cnt_nx == CNT_W'(ADDR_W)) begin
                        st_d.cnt  = '0;
                        st_d.addr = sr_nx;
                        st_d.orem = '0;
                        st_d.ph   = PH_RD;
                    end
                end
                PH_WR: begin
                    st_d.sr  = sr_nx;
                    st_d.cnt = cnt_nx;
                    if (cnt_nx == CNT_W'(8)) begin
                        st_d.cfg_pend = 1'b1;
                        st_d.cfg_val  = {sr_nx[V_QUAD_BIT], sr_nx[V_DUAL_BIT]};
                        st_d.ph       = PH_SKIP;
                    end
                end
                default: ;
            endcase
        end else if (fall && st_q.ph == PH_RD) begin
            st_d.drive = 1'b1;
            if (st_q.orem == '0) st_d.addr = st_q.addr + 1'b1;
            case (st_q.dw)
                3'd1:    st_d.dout = {2'b00, byte_v[7], 1'b0};
                3'd2:    st_d.dout = {2'b00, byte_v[7:6]};
                default: st_d.dout = byte_v[7:4];
            endcase
            st_d.obyte = byte_v << st_q.dw;
            st_d.orem  = ((st_q.orem == '0) ? units_per_byte(st_q.dw) : st_q.orem) - 4'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mem_addr   = st_q.addr;
    assign dq_out     = st_q.dout;
    assign dq_oe      = st_q.drive ? lane_mask(st_q.dw) : 4'b0000;
    assign cfg_we     = cs_n_s & st_q.cfg_pend;
    assign cfg_wsel_n = st_q.cfg_val;

endmodule

// File: rtl/sfe_top.sv
module sfe_top
    import sfe_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        nv_sel_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic [3:0]        dq_in,
    output logic [3:0]        dq_out,
    output logic [3:0]        dq_oe,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rdata
);

    localparam int PIN_W = 6;

    logic [PIN_W-1:0] pins_s;
    logic             sck_s, cs_n_s;
    logic [3:0]       dq_s;
    lane_mode_e       mode;
    logic             cfg_we;
    logic [1:0]       cfg_wsel_n;

    sfe_sync #(
        .W       (PIN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (6'b10_0000)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({cs_n, sck, dq_in}),
        .dout  (pins_s)
    );

    assign cs_n_s = pins_s[5];
    assign sck_s  = pins_s[4];
    assign dq_s   = pins_s[3:0];

    sfe_cfg i_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .nv_sel_n (nv_sel_n),
        .we       (cfg_we),
        .wsel_n   (cfg_wsel_n),
        .mode     (mode)
    );

    sfe_engine #(
        .ADDR_W (ADDR_W)
    ) i_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .sck_s      (sck_s),
        .cs_n_s     (cs_n_s),
        .dq_s       (dq_s),
        .mode       (mode),
        .mem_rdata  (mem_rdata),
        .mem_addr   (mem_addr),
        .dq_out     (dq_out),
        .dq_oe      (dq_oe),
        .cfg_we     (cfg_we),
        .cfg_wsel_n (cfg_wsel_n)
    );

endmodule

// File: rtl/sfe_checker.sv
module sfe_checker
    import sfe_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       sck_s,
    input logic       cs_n_s,
    input logic [3:0] dq_out,
    input logic [3:0] dq_oe,
    input lane_mode_e mode
);

    logic sck_seen_q;
    logic fall_c;

    always_ff @(posedge clk) begin
        if (!rst_n) sck_seen_q <= 1'b0;
        else        sck_seen_q <= sck_s;
    end

    assign fall_c = sck_seen_q & ~sck_s;

    // R9: a released chip select frees every lane on the next cycle
    p_release_lanes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> (dq_oe == 4'b0000));

    // R10: only the three legal enable patterns ever appear
    p_oe_pattern_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe == 4'b0000) || (dq_oe == 4'b0010) || (dq_oe == 4'b0011) || (dq_oe == 4'b1111));

    // R11: driven data moves only after a falling serial clock edge
    p_out_on_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dq_out) |-> $past(fall_c));

    // R8: the lane mode switches only while chip select is released
    p_mode_at_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode) |-> $past(cs_n_s));

endmodule

bind sfe_top sfe_checker i_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .sck_s  (sck_s),
    .cs_n_s (cs_n_s),
    .dq_out (dq_out),
    .dq_oe  (dq_oe),
    .mode   (mode)
);

// File: tb/test_sfe_top.sv
`timescale 1ns/1ps
module test_sfe_top;

    localparam int HALF = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  nv_sel_n = 2'b11;
    logic        sck = 1'b0;
    logic        cs_n = 1'b1;
    logic [3:0]  dq_in = 4'h0;
    logic [3:0]  dq_out, dq_oe;
    logic [23:0] mem_addr;
    logic [7:0]  mem_rdata;

    int checks = 0;
    int fails  = 0;
    int cpol   = 0;
    int cur    = 1;

    always #2 clk = ~clk;

    function automatic logic [7:0] memf(logic [23:0] a);
        return (a[7:0] * 8'd37) ^ a[15:8] ^ a[23:16] ^ 8'h5A;
    endfunction

    assign mem_rdata = memf(mem_addr);

    sfe_top i_sfe_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .nv_sel_n  (nv_sel_n),
        .sck       (sck),
        .cs_n      (cs_n),
        .dq_in     (dq_in),
        .dq_out    (dq_out),
        .dq_oe     (dq_oe),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata)
    );

    task automatic check(string req, int got, int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic int mask_for(int w);
        return (w == 1) ? 2 : (w == 2) ? 3 : 15;
    endfunction

    task automatic do_reset(logic [1:0] nv);
        nv_sel_n = nv;
        sck = cpol[0];
        cs_n = 1'b1;
        rst_n = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        rst_n = 1'b1;
        cur = (!nv[1]) ? 4 : (!nv[0]) ? 2 : 1;   // R2 decode
        #(2*HALF);
        check("R1 lanes released after reset", int'(dq_oe), 0);
    endtask

    task automatic send(logic [23:0] v, int nbits, int w);
        for (int i = nbits / w - 1; i >= 0; i--) begin
            sck = 1'b0;
            dq_in = 4'((v >> (i * w)) & 24'((1 << w) - 1));
            #(HALF);
            sck = 1'b1;
            #(HALF);
        end
    endtask

    task automatic start_txn();
        sck = cpol[0];
        cs_n = 1'b0;
        #(HALF);
    endtask

    task automatic stop_txn();
        if (cpol == 0) sck = 1'b0;
        cs_n = 1'b1;
        dq_in = 4'h0;
        #(2*HALF);
    endtask

    task automatic read_txn(logic [7:0] op, logic [23:0] a, int nbytes, string tag);
        int dw;
        dw = (cur == 1) ? ((op == 8'h3B) ? 2 : (op == 8'h6B) ? 4 : 1) : cur;
        start_txn();
        send({16'h0, op}, 8, cur);
        send(a, 24, cur);
        for (int b = 0; b < nbytes; b++) begin
            logic [7:0] e;
            e = memf(24'(a + b));
            for (int i = 8 / dw - 1; i >= 0; i--) begin
                int got;
                logic [3:0] held;
                sck = 1'b0;
                #(HALF);
                got = (dw == 1) ? int'(dq_out[1]) : (dw == 2) ? int'(dq_out[1:0]) : int'(dq_out);
                check(tag, got, int'((e >> (i * dw)) & 8'((1 << dw) - 1)));
                check("R10 enable mask", int'(dq_oe), mask_for(dw));
                held = dq_out;
                sck = 1'b1;
                #(HALF/2);
                check("R11 held over rising edge", int'(dq_out), int'(held));
                #(HALF/2);
            end
        end
        stop_txn();
        check("R9 lanes released at chip-select high", int'(dq_oe), 0);
    endtask

    task automatic write_cfg(logic [7:0] v, int nbits);
        start_txn();
        send(24'h61, 8, cur);
        send(24'(v >> (8 - nbits)), nbits, cur);
        stop_txn();
    endtask

    initial begin
        logic [1:0]  nvs [4];
        logic [7:0]  ops [3];
        logic [23:0] adrs [2];
        nvs  = '{2'b11, 2'b10, 2'b01, 2'b00};
        ops  = '{8'h03, 8'h3B, 8'h6B};
        adrs = '{24'h0000FE, 24'hFFFFFF};

        // sweep: clock mode x power-up selection x read opcode x address
        for (int cp = 0; cp < 2; cp++) begin
            cpol = cp;
            for (int n = 0; n < 4; n++) begin
                do_reset(nvs[n]);
                read_txn(8'h03, 24'h000010, 1, "R2");
                for (int o = 0; o < 3; o++) begin
                    for (int k = 0; k < 2; k++) begin
                        string tag;
                        if (cp == 1)       tag = "R12";
                        else if (cur == 2) tag = "R6";
                        else if (cur == 4) tag = "R7";
                        else               tag = (o == 0) ? "R3" : (o == 1) ? "R4" : "R5";
                        read_txn(ops[o], adrs[k] ^ 24'(o * 24'h013579), 2, tag);
                    end
                end
            end
        end

        cpol = 0;
        do_reset(2'b11);

        // R10: unknown opcode keeps every lane released
        begin
            int bad;
            bad = 0;
            start_txn();
            send(24'h9F, 8, cur);
            for (int u = 0; u < 16; u++) begin
                sck = 1'b0;
                #(HALF);
                if (dq_oe != 4'h0) bad++;
                sck = 1'b1;
                #(HALF);
            end
            stop_txn();
            check("R10 unknown opcode left lanes released", bad, 0);
            read_txn(8'h03, 24'h00ABCD, 1, "R10");
        end

        // R9: abort inside the address, then a clean transaction
        start_txn();
        send(24'h03, 8, cur);
        send(24'hABC, 12, cur);
        stop_txn();
        check("R9 abort in address", int'(dq_oe), 0);
        read_txn(8'h03, 24'h000123, 1, "R9");

        // R9: abort inside the data phase
        start_txn();
        send(24'h03, 8, cur);
        send(24'h000200, 24, cur);
        sck = 1'b0; #(HALF); sck = 1'b1; #(HALF);
        stop_txn();
        check("R9 abort in data", int'(dq_oe), 0);

        // R8: volatile selection writes
        write_cfg(8'hBF, 8); cur = 2;
        read_txn(8'h03, 24'h004455, 2, "R8");
        read_txn(8'h6B, 24'h004456, 1, "R6");
        write_cfg(8'h7F, 8); cur = 4;
        read_txn(8'h03, 24'h001111, 2, "R8");
        write_cfg(8'h3F, 8); cur = 4;
        read_txn(8'h3B, 24'h002222, 1, "R8");
        write_cfg(8'hFF, 8); cur = 1;
        read_txn(8'h03, 24'h003333, 1, "R8");
        write_cfg(8'hBF, 4);          // incomplete byte: no change
        read_txn(8'h03, 24'h003334, 1, "R8");

        // R1: reset discards the override
        write_cfg(8'h7F, 8); cur = 4;
        read_txn(8'h03, 24'h005000, 1, "R8");
        do_reset(2'b11);
        read_txn(8'h03, 24'h005001, 1, "R1");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #600000;
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule